// File: doc/BRIEF.md
# Dual-Port RAM with Collision Arbitration and Mailbox Interrupts

This block is a synchronous model of a true dual-port memory. It has two fully independent ports, A and B. Each port has an active-low chip select, a write strobe that writes when low, an active-low output enable, an address and separate write and read data buses. When both ports are selected at the same address, an arbiter picks one port as the owner. The other port sees an active-low busy flag, and its writes are dropped for as long as that flag stays low.

The owner is the port that was already sitting on the address when the other port arrived. If both ports land on the same address in the same cycle, port A owns it. While a port is busy and keeps its address, select and strobe steady, its read register holds its value, even if the owner writes that location. It picks up fresh data once busy is released or once the busy port itself moves.

The two highest addresses serve as mailboxes for signalling between the ports. A write by A to the top location raises B's interrupt, and B clears it by reading that location. A write by B to the location one below the top raises A's interrupt, and A clears it the same way.

Top module: `dpram_arbiter`

## Requirements
- R1: A port writes memory on a clock edge only when its select is low, its strobe is low and its busy flag is high. Read data comes from a register loaded one edge after a read (select low, strobe high).
- R2: A port's busy output goes low only when both selects are low and the two addresses are equal. At most one busy output is low at any time.
- R3: Busy is released (high) in the same cycle that the addresses differ or the other port's select goes high.
- R4: A port whose select and address were unchanged since the previous edge owns the address against a port that changed its select or address. The newcomer gets busy low.
- R5: When both ports arrive at the same address in the same cycle, port A owns it and B's busy goes low.
- R6: Ownership stays fixed while both ports keep their select and address unchanged.
- R7: A write from a port whose busy is low leaves memory unchanged.
- R8: While a port is busy and its address, select and strobe are all unchanged since the previous edge, its read data holds. After release it shows the current memory contents one edge later.
- R9: Read data on a port is all zeros unless both its select and its output enable are low.
- R10: A qualified write by A to address 2^AW-1 drives B's interrupt (active low) low after the edge. A read of that address by B with output enable low drives it high again. If set and clear fall on the same edge, set wins.
- R11: A qualified write by B to address 2^AW-2 drives A's interrupt low after the edge. A read of that address by A with output enable low drives it high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_cs_n | input | 1 | Port A select, active low |
| a_we_n | input | 1 | Port A strobe, low writes, high reads |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_addr | input | AW | Port A address |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A read data, gated by select and output enable |
| a_busy_n | output | 1 | Port A collision flag, active low |
| a_irq_n | output | 1 | Port A mailbox interrupt, active low |
| b_cs_n | input | 1 | Port B select, active low |
| b_we_n | input | 1 | Port B strobe, low writes, high reads |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_addr | input | AW | Port B address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B read data, gated by select and output enable |
| b_busy_n | output | 1 | Port B collision flag, active low |
| b_irq_n | output | 1 | Port B mailbox interrupt, active low |

## Verification
Several properties are checked on every cycle: the two busy flags are never low together, busy never shows without both ports selected, a late arrival always loses and ownership never flips during a steady collision, a frozen read register never moves, and a mailbox write always raises the interrupt. Other behaviour only shows up in scenarios that look at memory afterwards. This includes dropped writes from the busy port, the old-then-new data seen across a freeze and its release, and the clearing of interrupts by reads. The bench covers these with directed sequences, plus random traffic confined to a few addresses so that collisions and mailbox hits happen often.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic {
    OWN_A = 1'b0,
    OWN_B = 1'b1
  } owner_e;
endpackage

// File: rtl/dpa_arbiter.sv
module dpa_arbiter
  import dpa_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_a,
  input  logic          en_b,
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  output logic          busy_a,
  output logic          busy_b
);
  logic          prev_en_a, prev_en_b;
  logic [AW-1:0] prev_addr_a, prev_addr_b;
  owner_e        own_q, own_d;
  logic          hit, stay_a, stay_b, keep;

  // Collision and arrival detection
  always_comb begin
    hit    = en_a && en_b && (addr_a == addr_b);
    stay_a = prev_en_a && (prev_addr_a == addr_a);
    stay_b = prev_en_b && (prev_addr_b == addr_b);
    keep   = hit && stay_a && stay_b;
    if (keep)                 own_d = own_q;
    else if (stay_b && !stay_a) own_d = OWN_B;
    else                      own_d = OWN_A;  // earlier A or same-cycle tie
    busy_a = hit && (own_d == OWN_B);
    busy_b = hit && (own_d == OWN_A);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_en_a   <= 1'b0;
      prev_en_b   <= 1'b0;
      prev_addr_a <= '0;
      prev_addr_b <= '0;
      own_q       <= OWN_A;
    end else begin
      prev_en_a   <= en_a;
      prev_en_b   <= en_b;
      prev_addr_a <= addr_a;
      prev_addr_b <= addr_b;
      own_q       <= own_d;
    end
  end

  AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy_a && busy_b)); // R2
  AST_BUSY_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
    (busy_a || busy_b) |-> (en_a && en_b)); // R3
  AST_LATE_LOSES: assert property (@(posedge clk) disable iff (rst)
    (hit && stay_a && !stay_b) |-> busy_b); // R4
  AST_OWNER_STICKS: assert property (@(posedge clk) disable iff (rst)
    ($past(busy_a) && keep) |-> busy_a); // R6
endmodule

// File: rtl/dpa_store.sv
module dpa_store #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           en,
  input  logic [1:0]           wr_n,
  input  logic [1:0]           busy,
  input  logic [1:0][AW-1:0]   addr,
  input  logic [1:0][DW-1:0]   wdata,
  output logic [1:0][DW-1:0]   rd,
  output logic [1:0]           we
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [1:0]    hold;

  // Write qualification: select, strobe and no collision loss
  always_comb begin
    for (int p = 0; p < 2; p++) we[p] = en[p] && !wr_n[p] && !busy[p];
  end

  // Single write process; owner and loser never write the same cycle at one address
  always_ff @(posedge clk) begin
    if (we[0]) mem[addr[0]] <= wdata[0];
    if (we[1]) mem[addr[1]] <= wdata[1];
  end

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic          prev_en, prev_wr_n;
    logic [AW-1:0] prev_addr;

    always_comb hold[p] = busy[p] && prev_en && (prev_addr == addr[p]) && (prev_wr_n == wr_n[p]);

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_en   <= 1'b0;
        prev_wr_n <= 1'b1;
        prev_addr <= '0;
        rd[p]     <= '0;
      end else begin
        prev_en   <= en[p];
        prev_wr_n <= wr_n[p];
        prev_addr <= addr[p];
        if (en[p] && wr_n[p] && !hold[p]) rd[p] <= mem[addr[p]];
      end
    end

    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      hold[p] |=> $stable(rd[p])); // R8
  end
endmodule

// File: rtl/dpa_mailbox.sv
module dpa_mailbox #(
  parameter int          AW   = 10,
  parameter logic [AW-1:0] SLOT = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          peer_we,
  input  logic [AW-1:0] peer_addr,
  input  logic          own_en,
  input  logic          own_wr_n,
  input  logic          own_oe_n,
  input  logic [AW-1:0] own_addr,
  output logic          irq
);
  logic set_evt, clr_evt;

  always_comb begin
    set_evt = peer_we && (peer_addr == SLOT);
    clr_evt = own_en && own_wr_n && !own_oe_n && (own_addr == SLOT);
  end

  always_ff @(posedge clk) begin
    if (rst)          irq <= 1'b0;
    else if (set_evt) irq <= 1'b1;
    else if (clr_evt) irq <= 1'b0;
  end

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> irq); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!set_evt && !clr_evt) |=> $stable(irq)); // R11
endmodule

// File: rtl/dpram_arbiter.sv
module dpram_arbiter #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_cs_n,
  input  logic          a_we_n,
  input  logic          a_oe_n,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_busy_n,
  output logic          a_irq_n,
  input  logic          b_cs_n,
  input  logic          b_we_n,
  input  logic          b_oe_n,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_busy_n,
  output logic          b_irq_n
);
  localparam logic [AW-1:0] SLOT_TO_B = {AW{1'b1}};
  localparam logic [AW-1:0] SLOT_TO_A = {AW{1'b1}} - 1'b1;

  logic               en_a, en_b, busy_a, busy_b, irq_a, irq_b;
  logic [1:0][DW-1:0] rd;
  logic [1:0]         we;

  assign en_a = !a_cs_n;
  assign en_b = !b_cs_n;

  dpa_arbiter #(.AW(AW)) i_arb (
    .clk(clk), .rst(rst), .en_a(en_a), .en_b(en_b),
    .addr_a(a_addr), .addr_b(b_addr), .busy_a(busy_a), .busy_b(busy_b)
  );

  dpa_store #(.AW(AW), .DW(DW)) i_store (
    .clk(clk), .rst(rst),
    .en({en_b, en_a}), .wr_n({b_we_n, a_we_n}), .busy({busy_b, busy_a}),
    .addr({b_addr, a_addr}), .wdata({b_wdata, a_wdata}),
    .rd(rd), .we(we)
  );

  dpa_mailbox #(.AW(AW), .SLOT(SLOT_TO_B)) i_mbox_b (
    .clk(clk), .rst(rst), .peer_we(we[0]), .peer_addr(a_addr),
    .own_en(en_b), .own_wr_n(b_we_n), .own_oe_n(b_oe_n), .own_addr(b_addr),
    .irq(irq_b)
  );

  dpa_mailbox #(.AW(AW), .SLOT(SLOT_TO_A)) i_mbox_a (
    .clk(clk), .rst(rst), .peer_we(we[1]), .peer_addr(b_addr),
    .own_en(en_a), .own_wr_n(a_we_n), .own_oe_n(a_oe_n), .own_addr(a_addr),
    .irq(irq_a)
  );

  assign a_rdata  = (en_a && !a_oe_n) ? rd[0] : '0;
  assign b_rdata  = (en_b && !b_oe_n) ? rd[1] : '0;
  assign a_busy_n = !busy_a;
  assign b_busy_n = !busy_b;
  assign a_irq_n  = !irq_a;
  assign b_irq_n  = !irq_b;

  AST_GATED_READ: assert property (@(posedge clk) disable iff (rst)
    (a_oe_n || a_cs_n) |-> (a_rdata == '0)); // R9
endmodule

// File: tb/test_dpram_arbiter.sv
`timescale 1ns/1ps
module test_dpram_arbiter;
  localparam int AW = 10;
  localparam int DW = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic a_cs_n = 1, a_we_n = 1, a_oe_n = 1, b_cs_n = 1, b_we_n = 1, b_oe_n = 1;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic a_busy_n, b_busy_n, a_irq_n, b_irq_n;

  always #4 clk = ~clk;

  dpram_arbiter #(.AW(AW), .DW(DW)) i_dpram_arbiter (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Reference model state
  logic [DW-1:0] mref [1024];
  logic m_pea, m_peb, m_pwa, m_pwb, m_own, m_ia, m_ib;
  logic [AW-1:0] m_pa, m_pb;
  logic [DW-1:0] m_rqa, m_rqb;
  logic lb_a, lb_b;  // busy_n seen in the last cycle

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_pea = 0; m_peb = 0; m_pwa = 1; m_pwb = 1; m_own = 0;
    m_ia = 0; m_ib = 0; m_pa = '0; m_pb = '0; m_rqa = '0; m_rqb = '0;
  endtask

  task automatic drive(logic acs, logic awe, logic aoe, int aa, int ad,
                       logic bcs, logic bwe, logic boe, int ba, int bd);
    a_cs_n = acs; a_we_n = awe; a_oe_n = aoe; a_addr = AW'(aa); a_wdata = DW'(ad);
    b_cs_n = bcs; b_we_n = bwe; b_oe_n = boe; b_addr = AW'(ba); b_wdata = DW'(bd);
  endtask

  // One cycle: inputs already driven after a falling edge
  task automatic cyc();
    logic ea, eb, hit, sa, sb, own, ba, bb, wea, web, ha, hb;
    #1;
    ea = !a_cs_n; eb = !b_cs_n;
    hit = ea && eb && (a_addr == b_addr);
    sa = m_pea && (m_pa == a_addr);
    sb = m_peb && (m_pb == b_addr);
    if (hit && sa && sb) own = m_own;
    else if (sb && !sa)  own = 1;
    else                 own = 0;
    ba = hit && own; bb = hit && !own;
    lb_a = a_busy_n; lb_b = b_busy_n;
    chk("R2 busy_a", a_busy_n, !ba);
    chk("R2 busy_b", b_busy_n, !bb);
    @(posedge clk);
    wea = ea && !a_we_n && !ba;
    web = eb && !b_we_n && !bb;
    ha = ba && m_pea && (m_pa == a_addr) && (m_pwa == a_we_n);
    hb = bb && m_peb && (m_pb == b_addr) && (m_pwb == b_we_n);
    if (ea && a_we_n && !ha) m_rqa = mref[a_addr];
    if (eb && b_we_n && !hb) m_rqb = mref[b_addr];
    if (wea && a_addr == 10'h3FF) m_ib = 1;
    else if (eb && b_we_n && !b_oe_n && b_addr == 10'h3FF) m_ib = 0;
    if (web && b_addr == 10'h3FE) m_ia = 1;
    else if (ea && a_we_n && !a_oe_n && a_addr == 10'h3FE) m_ia = 0;
    if (wea) mref[a_addr] = a_wdata;
    if (web) mref[b_addr] = b_wdata;
    m_pea = ea; m_peb = eb; m_pa = a_addr; m_pb = b_addr;
    m_pwa = a_we_n; m_pwb = b_we_n; m_own = own;
    @(negedge clk);
    chk("R8 rdata_a", a_rdata, (ea && !a_oe_n) ? m_rqa : '0);
    chk("R8 rdata_b", b_rdata, (eb && !b_oe_n) ? m_rqb : '0);
    chk("R10 irq_b", b_irq_n, !m_ib);
    chk("R11 irq_a", a_irq_n, !m_ia);
  endtask

  task automatic idle();
    drive(1, 1, 1, 0, 0, 1, 1, 1, 0, 0); cyc();
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int pool [6];
    pool = '{0, 1, 2, 3, 1022, 1023};
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // Reset state
    chk("R2 reset busy_a", a_busy_n, 1); chk("R2 reset busy_b", b_busy_n, 1);
    chk("R10 reset irq_b", b_irq_n, 1);  chk("R11 reset irq_a", a_irq_n, 1);
    chk("R9 reset rdata", a_rdata, 0);

    for (int i = 0; i < 16; i++) begin drive(0, 0, 1, i, 8'h10 + i, 1, 1, 1, 0, 0); cyc(); end

    // R1: write, read back, unselected write ignored
    drive(0, 0, 1, 5, 8'h3C, 1, 1, 1, 0, 0); cyc();
    drive(0, 1, 0, 5, 0, 1, 1, 1, 0, 0); cyc();
    chk("R1 readback", a_rdata, 8'h3C);
    drive(1, 0, 1, 5, 8'hFF, 1, 1, 1, 0, 0); cyc();
    drive(0, 1, 0, 5, 0, 1, 1, 1, 0, 0); cyc();
    chk("R1 deselected write", a_rdata, 8'h3C);
    // R9: output enable high gates data
    drive(0, 1, 1, 5, 0, 1, 1, 1, 0, 0); cyc();
    chk("R9 oe gated", a_rdata, 0);

    // R5 tie, R7 suppressed write
    idle();
    drive(0, 1, 1, 7, 0, 0, 1, 1, 7, 0); cyc();
    chk("R5 tie B busy", lb_b, 0); chk("R5 tie A free", lb_a, 1);
    drive(0, 1, 1, 7, 0, 0, 0, 1, 7, 8'hEE); cyc();
    chk("R7 B still busy", lb_b, 0);
    idle();
    drive(0, 1, 0, 7, 0, 1, 1, 1, 0, 0); cyc();
    chk("R7 blocked write", a_rdata, 8'h17);

    // R4 arrival order both ways
    idle();
    drive(0, 1, 1, 9, 0, 1, 1, 1, 0, 0); cyc();
    drive(0, 1, 1, 9, 0, 0, 1, 1, 9, 0); cyc();
    chk("R4 late B busy", lb_b, 0); chk("R4 early A free", lb_a, 1);
    idle();
    drive(1, 1, 1, 0, 0, 0, 1, 1, 11, 0); cyc();
    drive(0, 1, 1, 11, 0, 0, 1, 1, 11, 0); cyc();
    chk("R4 late A busy", lb_a, 0); chk("R4 early B free", lb_b, 1);
    // R3 release by mismatch and by other select
    drive(0, 1, 1, 12, 0, 0, 1, 1, 11, 0); cyc();
    chk("R3 mismatch release", lb_a, 1);
    drive(0, 1, 1, 11, 0, 0, 1, 1, 11, 0); cyc();
    chk("R4 re-arrive A busy", lb_a, 0);
    drive(0, 1, 1, 11, 0, 1, 1, 1, 11, 0); cyc();
    chk("R3 deselect release", lb_a, 1);

    // R8 freeze and R6 sticky ownership
    idle();
    drive(0, 0, 1, 12, 8'h22, 1, 1, 1, 0, 0); cyc();
    drive(0, 0, 1, 12, 8'h33, 0, 1, 0, 12, 0); cyc();
    chk("R4 B busy", lb_b, 0); chk("R8 first data", b_rdata, 8'h22);
    drive(0, 0, 1, 12, 8'h44, 0, 1, 0, 12, 0); cyc();
    chk("R6 owner kept", lb_b, 0); chk("R8 frozen", b_rdata, 8'h22);
    drive(1, 1, 1, 12, 0, 0, 1, 0, 12, 0); cyc();
    chk("R3 released", lb_b, 1); chk("R8 updated", b_rdata, 8'h44);

    // R10 and R11 mailboxes
    idle();
    drive(0, 0, 1, 1023, 8'h5A, 1, 1, 1, 0, 0); cyc();
    chk("R10 set", b_irq_n, 0);
    drive(1, 1, 1, 0, 0, 0, 1, 0, 1023, 0); cyc();
    chk("R10 clear", b_irq_n, 1); chk("R10 data", b_rdata, 8'h5A);
    drive(1, 1, 1, 0, 0, 0, 0, 1, 1022, 8'hA5); cyc();
    chk("R11 set", a_irq_n, 0);
    drive(0, 1, 0, 1022, 0, 1, 1, 1, 0, 0); cyc();
    chk("R11 clear", a_irq_n, 1); chk("R11 data", a_rdata, 8'hA5);

    // Random traffic on a small address pool
    for (int i = 0; i < 4; i++) begin drive(0, 0, 1, i, 8'h40 + i, 1, 1, 1, 0, 0); cyc(); end
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 4) == 0, ($urandom % 5) < 3, ($urandom % 10) < 3, pool[$urandom % 6], $urandom % 256,
            ($urandom % 4) == 0, ($urandom % 5) < 3, ($urandom % 10) < 3, pool[$urandom % 6], $urandom % 256);
      cyc();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule